// File: doc/BRIEF.md
# Dual Gamepad Bus Interface

This block sits on an 8-bit parallel expansion bus as a peripheral that reads two serial-shift-register gamepads. The host starts a scan with a write to the latch address ($C), which pulses the shared latch line so that both pads capture their buttons. Each later write to the shift address ($D) sends one clock pulse to both pads. On that pulse the block samples each pad's serial data line into its own 8-bit status register.

A host read of $C returns the status byte of pad 0, and a read of $D returns that of pad 1. The bus side is sampled by the block clock. A write takes effect only once its select has been released. The data bus is driven only during a read of one of the two owned addresses.

Top module: `dual_pad_port`

## Requirements
- R1: A synchronous reset clears both status registers to 8'h00 and holds the latch and clock outputs low.
- R2: A completed write to address $C produces exactly one latch pulse, one clock cycle wide, and no pad clock pulse.
- R3: A completed write to address $D produces exactly one pad clock pulse, one clock cycle wide, and no latch pulse; latch and clock are never high together.
- R4: On each $D write, each status register shifts right by one and takes that pad's data line into bit 7. After a latch and eight shifts, bit 0 therefore holds the first bit the pad sent.
- R5: A read (select low, write enable high) of $C returns pad 0's status byte; a read of $D returns pad 1's status byte.
- R6: The data bus is high impedance unless select is low, write enable is high and the address is $C or $D.
- R7: A write acts only after select is deasserted (its rising edge); no pulse appears while select stays low.
- R8: Read data stays stable for as long as the select and the address are held.
- R9: Writes to addresses other than $C and $D, and reads of any address, produce no pulse and leave the status registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Bus address |
| bus_sel_n | input | 1 | Bus select, active low |
| bus_wr_n | input | 1 | Write enable, active low |
| bus_data | inout | 8 | Bidirectional bus data |
| pad_latch | output | 1 | Latch pulse to both pads |
| pad_clk | output | 1 | Shift clock pulse to both pads |
| pad_dat0 | input | 1 | Serial data from pad 0 |
| pad_dat1 | input | 1 | Serial data from pad 1 |

## Verification
Full scans are run with the pad pairs A5/3C, FF/00 and 01/80. Because the two pads differ, a swapped register, a reversed bit order or a pad read at the wrong address gives a different byte. A ninth shift pulls in the idle-high fill bit, which shows the shift direction and the entry bit. Writes held low for many cycles, writes to other addresses and reads of the owned addresses separate release-edge triggering from level or decode faults. Long held reads check the stability of the driven byte, and reads of a foreign address check the tristate.

// File: rtl/dual_pad_port.sv
module dual_pad_port #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter logic [AW-1:0] LATCH_ADDR = 4'hC,
  parameter logic [AW-1:0] SHIFT_ADDR = 4'hD
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_sel_n,
  input  logic          bus_wr_n,
  inout  wire  [DW-1:0] bus_data,
  output logic          pad_latch,
  output logic          pad_clk,
  input  logic          pad_dat0,
  input  logic          pad_dat1
);
  logic          sel_s, wr_s, sel_d, cap_wr;
  logic [AW-1:0] addr_s, cap_addr;
  logic [DW-1:0] stat0, stat1;
  logic          release_w, do_latch, do_shift, rd_en;

  assign release_w = sel_s && !sel_d;
  assign do_latch  = release_w && cap_wr && (cap_addr == LATCH_ADDR);
  assign do_shift  = release_w && cap_wr && (cap_addr == SHIFT_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_s     <= 1'b1;
      wr_s      <= 1'b1;
      addr_s    <= '0;
      sel_d     <= 1'b1;
      cap_wr    <= 1'b0;
      cap_addr  <= '0;
      pad_latch <= 1'b0;
      pad_clk   <= 1'b0;
      stat0     <= '0;
      stat1     <= '0;
    end else begin
      sel_s     <= bus_sel_n;
      wr_s      <= bus_wr_n;
      addr_s    <= bus_addr;
      sel_d     <= sel_s;
      if (!sel_s) begin
        cap_wr   <= !wr_s;
        cap_addr <= addr_s;
      end
      pad_latch <= do_latch;
      pad_clk   <= do_shift;
      if (do_shift) begin
        stat0 <= {pad_dat0, stat0[DW-1:1]};
        stat1 <= {pad_dat1, stat1[DW-1:1]};
      end
    end
  end

  assign rd_en = !bus_sel_n && bus_wr_n &&
                 (bus_addr == LATCH_ADDR || bus_addr == SHIFT_ADDR);
  assign bus_data = rd_en ? ((bus_addr == SHIFT_ADDR) ? stat1 : stat0) : 'z;
endmodule

module dual_pad_port_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic          bus_sel_n,
  input logic          bus_wr_n,
  input logic [DW-1:0] bus_data,
  input logic          pad_latch,
  input logic          pad_clk
);
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (!pad_latch && !pad_clk));
  p_latch_width_r2: assert property (@(posedge clk) disable iff (rst)
    pad_latch |=> !pad_latch);
  p_clk_width_r3: assert property (@(posedge clk) disable iff (rst)
    pad_clk |=> !pad_clk);
  p_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(pad_latch && pad_clk));
  p_after_release_r7: assert property (@(posedge clk) disable iff (rst)
    (pad_latch || pad_clk) |-> $past(bus_sel_n));
  p_read_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (!bus_sel_n && bus_wr_n && $past(!bus_sel_n && bus_wr_n) && $stable(bus_addr))
      |-> $stable(bus_data));
endmodule

bind dual_pad_port dual_pad_port_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_sel_n(bus_sel_n),
  .bus_wr_n(bus_wr_n), .bus_data(bus_data), .pad_latch(pad_latch), .pad_clk(pad_clk)
);

// File: tb/tb_dual_pad_port.sv
`timescale 1ns/1ps
module tb_dual_pad_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bus_addr = 4'h0;
  logic       bus_sel_n = 1'b1;
  logic       bus_wr_n = 1'b1;
  wire  [7:0] bus_data;
  logic       tb_oe = 1'b0;
  logic [7:0] tb_dout = 8'h00;
  logic       pad_latch, pad_clk;
  logic [7:0] sr0 = 8'hFF, sr1 = 8'hFF, btn0 = 8'h00, btn1 = 8'h00;
  int         n_chk = 0, n_fail = 0, lat_cnt = 0, clk_cnt = 0;
  logic       done = 1'b0;

  always #2.5 clk = ~clk;
  assign bus_data = tb_oe ? tb_dout : 'z;

  dual_pad_port dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_sel_n(bus_sel_n),
    .bus_wr_n(bus_wr_n), .bus_data(bus_data), .pad_latch(pad_latch),
    .pad_clk(pad_clk), .pad_dat0(sr0[0]), .pad_dat1(sr1[0])
  );

  always @(posedge clk) begin
    if (pad_latch) begin sr0 <= btn0; sr1 <= btn1; end
    else if (pad_clk) begin sr0 <= {1'b1, sr0[7:1]}; sr1 <= {1'b1, sr1[7:1]}; end
    if (pad_latch) lat_cnt <= lat_cnt + 1;
    if (pad_clk)   clk_cnt <= clk_cnt + 1;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input int hold);
    @(negedge clk);
    bus_addr = a; bus_wr_n = 1'b0; bus_sel_n = 1'b0; tb_oe = 1'b1; tb_dout = 8'h5A;
    repeat (hold) @(negedge clk);
    bus_sel_n = 1'b1; bus_wr_n = 1'b1; tb_oe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr_n = 1'b1; bus_sel_n = 1'b0;
    @(negedge clk);
    d = bus_data;
    bus_sel_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 latch low", {7'd0, pad_latch}, 8'h00);
    check("R1 clk low", {7'd0, pad_clk}, 8'h00);
    bus_read(4'hC, d); check("R1 pad0 status", d, 8'h00);
    bus_read(4'hD, d); check("R1 pad1 status", d, 8'h00);
    check("R6 idle hi-z", bus_data, 8'hzz);
  endtask

  task automatic t_pulses;
    int l0, c0;
    l0 = lat_cnt; c0 = clk_cnt;
    bus_write(4'hC, 2);
    check("R2 one latch", 8'(lat_cnt - l0), 8'd1);
    check("R2 no clk", 8'(clk_cnt - c0), 8'd0);
    l0 = lat_cnt; c0 = clk_cnt;
    bus_write(4'hD, 2);
    check("R3 one clk", 8'(clk_cnt - c0), 8'd1);
    check("R3 no latch", 8'(lat_cnt - l0), 8'd0);
  endtask

  task automatic t_hold;
    int l0;
    l0 = lat_cnt;
    @(negedge clk);
    bus_addr = 4'hC; bus_wr_n = 1'b0; bus_sel_n = 1'b0; tb_oe = 1'b1; tb_dout = 8'hA3;
    repeat (10) @(negedge clk);
    check("R7 no pulse while selected", 8'(lat_cnt - l0), 8'd0);
    check("R6 no drive on write", bus_data, 8'hA3);
    bus_sel_n = 1'b1; bus_wr_n = 1'b1; tb_oe = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 pulse after release", 8'(lat_cnt - l0), 8'd1);
  endtask

  task automatic t_scan(input logic [7:0] b0, input logic [7:0] b1);
    logic [7:0] d;
    btn0 = b0; btn1 = b1;
    bus_write(4'hC, 2);
    for (int i = 0; i < 8; i++) bus_write(4'hD, 1);
    bus_read(4'hC, d); check("R4 R5 pad0 scan", d, b0);
    bus_read(4'hD, d); check("R4 R5 pad1 scan", d, b1);
  endtask

  task automatic t_overshift;
    logic [7:0] d;
    btn0 = 8'h96; btn1 = 8'h42;
    bus_write(4'hC, 2);
    for (int i = 0; i < 9; i++) bus_write(4'hD, 1);
    bus_read(4'hC, d); check("R4 pad0 ninth shift", d, {1'b1, 7'h4B});
    bus_read(4'hD, d); check("R4 pad1 ninth shift", d, {1'b1, 7'h21});
  endtask

  task automatic t_ignored;
    logic [7:0] d;
    int l0, c0;
    l0 = lat_cnt; c0 = clk_cnt;
    bus_write(4'hB, 2);
    bus_write(4'h5, 2);
    bus_write(4'hE, 2);
    bus_read(4'hC, d);
    bus_read(4'hD, d);
    check("R9 no latch", 8'(lat_cnt - l0), 8'd0);
    check("R9 no clk", 8'(clk_cnt - c0), 8'd0);
    bus_read(4'hC, d); check("R9 pad0 kept", d, {1'b1, 7'h4B});
    bus_read(4'hD, d); check("R9 pad1 kept", d, {1'b1, 7'h21});
  endtask

  task automatic t_hiz;
    @(negedge clk);
    bus_addr = 4'h5; bus_wr_n = 1'b1; bus_sel_n = 1'b0;
    @(negedge clk); check("R6 foreign read hi-z", bus_data, 8'hzz);
    bus_addr = 4'hC; bus_sel_n = 1'b1;
    @(negedge clk); check("R6 unselected hi-z", bus_data, 8'hzz);
    bus_sel_n = 1'b0;
    @(negedge clk); check("R6 owned read driven", bus_data, {1'b1, 7'h4B});
    bus_sel_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_stable;
    logic [7:0] first;
    @(negedge clk);
    bus_addr = 4'hD; bus_wr_n = 1'b1; bus_sel_n = 1'b0;
    @(negedge clk); first = bus_data;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); check("R8 read held", bus_data, first);
    end
    bus_sel_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_pulses();
    t_hold();
    t_scan(8'hA5, 8'h3C);
    t_scan(8'hFF, 8'h00);
    t_scan(8'h01, 8'h80);
    t_overshift();
    t_ignored();
    t_hiz();
    t_stable();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule